// File: doc/BRIEF.md
# Network Bit Clock Generator with Link Status Monitor

This block makes the bit clock for a shared serial network and reports whether the local data link controller may transmit. The input is a 6 MHz tick, given as a one-cycle enable on the system clock. The block halves this tick to form a 3 MHz reference. A programmable counter restarts each time it reaches a selected terminal count, and that sets the base rate. A postscaler then divides the base rate by 1, 2 or 4. The clock level toggles once per postscaler period. It reaches the network pin only while this station is enabled as the clock source.

On the receive side, the block synchronises the clock it sees on the network to the system clock. Each rising edge of that clock restarts a carrier timeout, and carrier detect stays high while the timeout is running. The block also synchronises the two collision comparator outputs and flags a collision when both are high. A disconnected line drives both high, so it looks like a collision. Clear-to-send needs a live carrier and no collision.

Top module: `netclk_gen`

## Requirements
- R1: The reference strobe occurs on every second `tick6` pulse after reset. When `tick6` is high every other cycle, the output half period is twice as long as when `tick6` is high every cycle.
- R2: The base divider restarts after N reference strobes, where N = 3 + `divSel`. A `divSel` code whose N would exceed 5 saturates at N = 5, so code 3 behaves like code 2.
- R3: The postscale factor P is 1 for `postSel` = 0, 2 for `postSel` = 1, and 4 for `postSel` = 2 or 3.
- R4: The clock level starts low after reset and toggles every N*P reference strobes. With `tick6` high every cycle, the half period is 2*N*P system cycles.
- R5: While `srcEn` is low, `netClkOut` stays low for the whole time.
- R6: A rising edge on `rxClk` raises `carrierDet` three cycles after the edge is presented.
- R7: After the last rising edge on `rxClk`, `carrierDet` stays high for exactly `CD_TIMEOUT` cycles and then drops.
- R8: `collision` is high exactly when both `collA` and `collB` are high. It follows them two cycles later.
- R9: `clearToSend` equals `carrierDet` and not `collision`.
- R10: After reset, `netClkOut`, `carrierDet`, `collision` and `clearToSend` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick6 | input | 1 | 6 MHz enable pulse, one system cycle wide |
| divSel | input | 2 | Base divider select, N = 3 + divSel, saturating at 5 |
| postSel | input | 2 | Postscale select: 1, 2, 4, 4 |
| srcEn | input | 1 | Station is the network clock source |
| rxClk | input | 1 | Network clock as seen by the receive comparator |
| collA | input | 1 | First collision comparator output |
| collB | input | 1 | Second collision comparator output |
| netClkOut | output | 1 | Gated network bit clock toward the line driver |
| carrierDet | output | 1 | Network clock present |
| collision | output | 1 | Both comparator outputs high |
| clearToSend | output | 1 | Carrier present and no collision |

## Verification
The assertions assume that `tick6` is a synchronous enable. They also assume that `rxClk`, `collA` and `collB` may be asynchronous but are seen only through the two-flop synchronisers, so every property is written against the synchronised view. The stimulus changes all inputs on the falling clock edge, and it changes divider selects only when a measurement discards the first two half periods after the change. Some measurements loop the gated clock back into `rxClk`, so the carrier timeout also sees edges that the block itself produced.

// File: rtl/nclk_pkg.sv
package nclk_pkg;
  typedef struct packed {
    logic refTick;
    logic baseWrap;
    logic toggle;
  } nclkStrobe_t;
endpackage

// File: rtl/nclk_ctrl.sv
module nclk_ctrl
  import nclk_pkg::*;
#(
  parameter int BASE_DIV = 3,
  parameter int MAX_DIV  = 5,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick6,
  input  logic [SEL_W-1:0] divSel,
  input  logic [1:0]       postSel,
  output nclkStrobe_t      strb
);
  localparam int CNT_W  = $clog2(MAX_DIV + 1);
  localparam int POST_W = 2;

  logic             halfPh;
  logic [CNT_W-1:0] baseCnt;
  logic [CNT_W-1:0] tcM1;
  logic [POST_W-1:0] postCnt;
  logic [POST_W-1:0] pcM1;
  logic             refTick;
  logic             baseWrap;
  logic             postTick;

  always_comb begin
    int sumN;
    sumN = BASE_DIV + int'(divSel);
    if (sumN > MAX_DIV) sumN = MAX_DIV;
    tcM1 = CNT_W'(sumN - 1);
  end

  always_comb begin
    case (postSel)
      2'd0:    pcM1 = POST_W'(0);
      2'd1:    pcM1 = POST_W'(1);
      default: pcM1 = POST_W'(3);
    endcase
  end

  assign refTick  = tick6 & halfPh;
  assign baseWrap = refTick & (baseCnt >= tcM1);
  assign postTick = baseWrap & (postCnt >= pcM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) halfPh <= 1'b0;
    else if (tick6) halfPh <= ~halfPh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baseCnt <= '0;
    else if (baseWrap) baseCnt <= '0;
    else if (refTick) baseCnt <= baseCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) postCnt <= '0;
    else if (postTick) postCnt <= '0;
    else if (baseWrap) postCnt <= postCnt + 1'b1;
  end

  assign strb.refTick  = refTick;
  assign strb.baseWrap = baseWrap;
  assign strb.toggle   = postTick;

  // R1: two reference strobes never fall on back-to-back cycles
  p_ref_spacing_r1: assert property (@(posedge clk) disable iff (!rstN)
    refTick |=> !refTick);

  // R2: reaching the terminal count restarts the base counter
  p_base_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    (refTick && baseCnt >= tcM1) |=> baseCnt == '0);

  // R3: the postscaler only advances when the base counter wraps
  p_post_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !baseWrap |=> $stable(postCnt));
endmodule

// File: rtl/nclk_dpath.sv
module nclk_dpath
  import nclk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  nclkStrobe_t strb,
  input  logic        srcEn,
  output logic        netClkOut
);
  logic netClkReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) netClkReg <= 1'b0;
    else if (strb.toggle) netClkReg <= ~netClkReg;
  end

  assign netClkOut = netClkReg & srcEn;

  // R4: the clock level moves only on a postscaler strobe
  p_toggle_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.toggle |=> $stable(netClkReg));

  // R5: a rising output edge needs the source enable
  p_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(netClkOut) |-> srcEn);
endmodule

// File: rtl/nclk_linkmon.sv
module nclk_linkmon #(
  parameter int CD_TIMEOUT = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxClk,
  input  logic collA,
  input  logic collB,
  output logic carrierDet,
  output logic collision,
  output logic clearToSend
);
  localparam int TMR_W = $clog2(CD_TIMEOUT + 1);

  logic [1:0]       rxSync;
  logic             rxPrev;
  logic [1:0]       aSync;
  logic [1:0]       bSync;
  logic [TMR_W-1:0] timer;
  logic             rxEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync <= '0;
      rxPrev <= 1'b0;
      aSync  <= '0;
      bSync  <= '0;
    end else begin
      rxSync <= {rxSync[0], rxClk};
      rxPrev <= rxSync[1];
      aSync  <= {aSync[0], collA};
      bSync  <= {bSync[0], collB};
    end
  end

  assign rxEdge = rxSync[1] & ~rxPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timer <= '0;
    else if (rxEdge) timer <= TMR_W'(CD_TIMEOUT);
    else if (timer != '0) timer <= timer - 1'b1;
  end

  assign carrierDet  = (timer != '0);
  assign collision   = aSync[1] & bSync[1];
  assign clearToSend = carrierDet & ~collision;

  // R6: a synchronised rising edge always yields carrier on the next cycle
  p_carrier_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxEdge |=> carrierDet);

  // R7: the last count of the timeout ends the carrier unless retriggered
  p_carrier_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEdge && timer == TMR_W'(1)) |=> !carrierDet);

  // R9: clear-to-send never appears while a collision is flagged
  p_cts_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    collision |-> !clearToSend);
endmodule

// File: rtl/netclk_gen.sv
module netclk_gen
  import nclk_pkg::*;
#(
  parameter int BASE_DIV   = 3,
  parameter int MAX_DIV    = 5,
  parameter int SEL_W      = 2,
  parameter int CD_TIMEOUT = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick6,
  input  logic [SEL_W-1:0] divSel,
  input  logic [1:0]       postSel,
  input  logic             srcEn,
  input  logic             rxClk,
  input  logic             collA,
  input  logic             collB,
  output logic             netClkOut,
  output logic             carrierDet,
  output logic             collision,
  output logic             clearToSend
);
  nclkStrobe_t strb;

  nclk_ctrl #(.BASE_DIV(BASE_DIV), .MAX_DIV(MAX_DIV), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick6(tick6), .divSel(divSel),
    .postSel(postSel), .strb(strb)
  );

  nclk_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .srcEn(srcEn), .netClkOut(netClkOut)
  );

  nclk_linkmon #(.CD_TIMEOUT(CD_TIMEOUT)) u_link (
    .clk(clk), .rstN(rstN), .rxClk(rxClk), .collA(collA), .collB(collB),
    .carrierDet(carrierDet), .collision(collision), .clearToSend(clearToSend)
  );
endmodule

// File: tb/sim_netclk_gen.sv
module sim_netclk_gen;
  localparam int T_OUT = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick6 = 1'b0;
  logic [1:0] divSel = '0;
  logic [1:0] postSel = '0;
  logic srcEn = 1'b0;
  logic loopBack = 1'b0;
  logic rxManual = 1'b0;
  logic collA = 1'b0;
  logic collB = 1'b0;
  logic rxClk;
  logic netClkOut, carrierDet, collision, clearToSend;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic tickAlt = 1'b0;

  always #2 clk = ~clk;

  assign rxClk = loopBack ? netClkOut : rxManual;

  netclk_gen #(.CD_TIMEOUT(T_OUT)) u0 (
    .clk(clk), .rstN(rstN), .tick6(tick6), .divSel(divSel), .postSel(postSel),
    .srcEn(srcEn), .rxClk(rxClk), .collA(collA), .collB(collB),
    .netClkOut(netClkOut), .carrierDet(carrierDet), .collision(collision),
    .clearToSend(clearToSend)
  );

  // {divSel, postSel, expected half period in cycles with tick6 always high}
  typedef struct packed { logic [1:0] d; logic [1:0] p; logic [7:0] half; } vec_t;
  localparam vec_t VECS [8] = '{
    '{2'd0, 2'd0, 8'd6},  '{2'd1, 2'd0, 8'd8},  '{2'd2, 2'd0, 8'd10},
    '{2'd3, 2'd0, 8'd10}, '{2'd0, 2'd1, 8'd12}, '{2'd1, 2'd2, 8'd32},
    '{2'd2, 2'd3, 8'd40}, '{2'd0, 2'd3, 8'd24}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int half);
    logic prev;
    int n;
    for (int k = 0; k < 2; k++) begin
      n = 0; prev = netClkOut;
      while (netClkOut == prev && n < 1000) begin @(negedge clk); n++; end
    end
    n = 0; prev = netClkOut;
    while (netClkOut == prev && n < 1000) begin @(negedge clk); n++; end
    half = n;
  endtask

  always @(posedge clk) if (tickAlt) tick6 <= ~tick6;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!netClkOut && !carrierDet && !collision && !clearToSend, "R10 outputs in reset",
          {netClkOut, carrierDet, collision, clearToSend}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!netClkOut && !carrierDet && !collision && !clearToSend, "R10 outputs after reset",
          {netClkOut, carrierDet, collision, clearToSend}, 0);

    // R2 R3 R4 table of divider settings
    tick6 = 1'b1; srcEn = 1'b1;
    foreach (VECS[i]) begin
      divSel = VECS[i].d; postSel = VECS[i].p;
      measure(h);
      check(h == int'(VECS[i].half), $sformatf("R2 R3 R4 half period div=%0d post=%0d",
            VECS[i].d, VECS[i].p), h, int'(VECS[i].half));
    end

    // R1 tick6 every other cycle doubles the half period
    divSel = 2'd0; postSel = 2'd0;
    tick6 = 1'b0; tickAlt = 1'b1;
    measure(h);
    check(h == 12, "R1 half period with alternate tick6", h, 12);
    tickAlt = 1'b0; @(negedge clk); tick6 = 1'b1;

    // R5 gating
    srcEn = 1'b0;
    @(negedge clk);
    begin
      int highs = 0;
      for (int k = 0; k < 100; k++) begin @(negedge clk); if (netClkOut) highs++; end
      check(highs == 0, "R5 output held low while not source", highs, 0);
    end

    // R9 loopback: carrier present, no collision
    srcEn = 1'b1; loopBack = 1'b1; divSel = 2'd2; postSel = 2'd3;
    repeat (100) @(negedge clk);
    check(carrierDet == 1'b1, "R6 carrier with looped clock", carrierDet, 1);
    check(clearToSend == 1'b1, "R9 clear to send with carrier", clearToSend, 1);

    // R8 collision combinations while carrier is live
    collA = 1'b1; collB = 1'b0; repeat (3) @(negedge clk);
    check(!collision && clearToSend, "R8 only one comparator high", {collision, clearToSend}, 1);
    collA = 1'b0; collB = 1'b1; repeat (3) @(negedge clk);
    check(!collision && clearToSend, "R8 other comparator high", {collision, clearToSend}, 1);
    collA = 1'b1; collB = 1'b1; @(negedge clk);
    check(!collision, "R8 collision not before sync delay", collision, 0);
    @(negedge clk);
    check(collision && !clearToSend && carrierDet, "R8 R9 both high blocks send",
          {collision, clearToSend, carrierDet}, 5);
    collA = 1'b0; collB = 1'b0; repeat (3) @(negedge clk);
    check(!collision && clearToSend, "R9 send resumes", {collision, clearToSend}, 1);

    // R7 clock removed: carrier decays
    srcEn = 1'b0;
    repeat (T_OUT + 90) @(negedge clk);
    check(!carrierDet && !clearToSend, "R7 carrier lost after clock stops",
          {carrierDet, clearToSend}, 0);

    // R6 R7 exact timing with a single manual edge
    loopBack = 1'b0; rxManual = 1'b0;
    repeat (5) @(negedge clk);
    rxManual = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    check(!carrierDet, "R6 carrier not before third cycle", carrierDet, 0);
    @(posedge clk); @(negedge clk);
    check(carrierDet, "R6 carrier on third cycle", carrierDet, 1);
    repeat (T_OUT - 1) @(posedge clk); @(negedge clk);
    check(carrierDet, "R7 carrier still high at last timeout cycle", carrierDet, 1);
    @(posedge clk); @(negedge clk);
    check(!carrierDet, "R7 carrier dropped after timeout", carrierDet, 0);
    collA = 1'b1; collB = 1'b1; repeat (3) @(negedge clk);
    check(collision && !clearToSend, "R8 disconnected line is a collision",
          {collision, clearToSend}, 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule